// File: doc/BRIEF.md
# Maskable Routed Interrupt Controller

This block collects sixteen interrupt requests for a small embedded processor and turns them into two interrupt lines: one for the local processor and one for an external host. Every request is latched into a pending register. Software can set or clear pending bits through dedicated write-1 locations, and it can enable or disable each source the same way. A readback location shows the pending bits and another shows the enables.

Each source has its own trigger type. In edge mode a rising input latches the bit until software clears it. In level mode the bit tracks the input. A 32-bit routing word gives each source a route-enable bit and a target bit. Sources that are not routed drive the local line. Sources that are routed with target 1 drive the host line. A one-bit summary location lets the host see whether its line is active.

Source numbering: 0 general timer, 1 watchdog, 2 command, 3 context switch, 4 halt, 5 external error, 6 and 7 software, 8 to 15 external lines. Writes take effect at the next clock edge. Reads are combinational from `rd_addr`.

Top module: `irqc_top`

## Requirements
- R1: While `rst` is high and right after it, pending, mask, mode and routing all read 0, and both interrupt outputs are low.
- R2: Writing offset 0x000 sets every pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R3: Writing offset 0x004 clears every edge-mode pending bit whose data bit is 1, unless a rising edge arrives on that source in the same cycle.
- R4: When a source's mode bit is 0 (edge mode), a 0-to-1 transition of its input sets the pending bit at the next clock edge. The bit stays set after the input falls.
- R5: When a source's mode bit is 1 (level mode), its pending bit equals the input sampled at the previous clock edge. Writes to the set and clear locations have no effect on that bit.
- R6: When a rising edge and a software clear reach the same bit in the same cycle, the bit ends up set.
- R7: Writing offset 0x010 enables the sources whose data bit is 1. Writing 0x014 disables them. Offset 0x018 reads back the enables in bits 15:0.
- R8: Offset 0x00C holds the mode bits (1 means level, 0 means edge) in bits 15:0. Offset 0x01C holds the routing word: route enables in bits 15:0 and target bits in bits 31:16, with bit n (or n+16) belonging to source n. Both can be written and read back.
- R9: `irq_local` is high exactly when some source is pending, enabled and has its route enable at 0.
- R10: `irq_host` is high exactly when some source is pending, enabled, routed, and has target 1. A routed source with target 0 drives neither output.
- R11: Offset 0x020 reads the host line state in bit 0. All its other bits read 0.
- R12: Writes to 0x008, 0x018 and 0x020 change nothing. Offsets 0x000, 0x004, 0x010 and 0x014 read as 0. Offset 0x008 reads the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 16 | Interrupt request inputs, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| irq_local | output | 1 | Interrupt line to the local processor |
| irq_host | output | 1 | Interrupt line to the external host |

## Verification
A wrong pending bit shows up at the status location and, if the source is enabled, on one of the two lines, one clock edge after the input or write that caused it. A corrupted mask, mode or routing bit shows up at its own readback at once. For an edge-mode source it also affects the lines only while the source is pending, so each source is driven pending and then steered to both outputs in turn. Level-mode faults show up when an input falls, so the pending bit is checked both while the input is held high and after it drops.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_SRC = 16;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int SRC_W   = $clog2(NUM_SRC);

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // register byte offsets
    typedef enum logic [ADDR_W-1:0] {
        OFF_PSET = 8'h00,
        OFF_PCLR = 8'h04,
        OFF_STAT = 8'h08,
        OFF_MODE = 8'h0C,
        OFF_MSET = 8'h10,
        OFF_MCLR = 8'h14,
        OFF_MASK = 8'h18,
        OFF_DEST = 8'h1C,
        OFF_SUMM = 8'h20
    } reg_off_e;

    // source slot numbering
    typedef enum logic [SRC_W-1:0] {
        SRC_GPTIMER   = 4'd0,
        SRC_WATCHDOG  = 4'd1,
        SRC_COMMAND   = 4'd2,
        SRC_CTXSWITCH = 4'd3,
        SRC_HALT      = 4'd4,
        SRC_EXTERR    = 4'd5,
        SRC_SOFT0     = 4'd6,
        SRC_SOFT1     = 4'd7,
        SRC_EXT_FIRST = 4'd8
    } src_id_e;

    // routing word: target select above, route enable below
    typedef struct packed {
        src_vec_t target;
        src_vec_t route;
    } dest_t;

    typedef struct packed {
        logic pset;
        logic pclr;
        logic mset;
        logic mclr;
        logic mode_wr;
        logic dest_wr;
    } wr_strb_t;

    function automatic wr_strb_t decode_write(input logic we, input logic [ADDR_W-1:0] addr);
        wr_strb_t s;
        s = '0;
        if (we) begin
            case (addr)
                OFF_PSET: s.pset    = 1'b1;
                OFF_PCLR: s.pclr    = 1'b1;
                OFF_MSET: s.mset    = 1'b1;
                OFF_MCLR: s.mclr    = 1'b1;
                OFF_MODE: s.mode_wr = 1'b1;
                OFF_DEST: s.dest_wr = 1'b1;
                default:  s         = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  wr_strb_t            strb,
    input  logic [DATA_W-1:0]   wdata,
    output src_vec_t            mask_q,
    output src_vec_t            mode_q,
    output dest_t               dest_q,
    output src_vec_t            sw_set,
    output src_vec_t            sw_clr
);

    src_vec_t wbits;
    assign wbits  = wdata[NUM_SRC-1:0];
    assign sw_set = strb.pset ? wbits : '0;
    assign sw_clr = strb.pclr ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            mode_q <= '0;
            dest_q <= '0;
        end else begin
            if (strb.mset)
                mask_q <= mask_q | wbits;
            else if (strb.mclr)
                mask_q <= mask_q & ~wbits;
            if (strb.mode_wr)
                mode_q <= wbits;
            if (strb.dest_wr)
                dest_q <= dest_t'(wdata);
        end
    end

    assert_mask_set_R7: assert property (@(posedge clk) disable iff (rst)
        strb.mset |=> ((mask_q & $past(wbits)) == $past(wbits)));

    assert_mask_clear_R7: assert property (@(posedge clk) disable iff (rst)
        strb.mclr |=> ((mask_q & $past(wbits)) == '0));

    assert_dest_write_R8: assert property (@(posedge clk) disable iff (rst)
        strb.dest_wr |=> (dest_q == $past(wdata)));

    assert_cfg_reset_R1: assert property (@(posedge clk)
        rst |=> (mask_q == '0 && mode_q == '0 && dest_q == '0));

endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t src,
    input  src_vec_t mode,
    input  src_vec_t sw_set,
    input  src_vec_t sw_clr,
    output src_vec_t pend_q
);

    src_vec_t src_q;
    src_vec_t pend_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            pend_q <= '0;
        end else begin
            src_q  <= src;
            pend_q <= pend_d;
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic rise;
        assign rise = src[i] & ~src_q[i];

        always_comb begin
            if (mode[i])
                pend_d[i] = src[i];
            else
                pend_d[i] = rise | sw_set[i] | (pend_q[i] & ~sw_clr[i]);
        end

        assert_edge_latch_R4: assert property (@(posedge clk) disable iff (rst)
            (!mode[i] && rise) |=> pend_q[i]);

        assert_edge_hold_R4: assert property (@(posedge clk) disable iff (rst)
            (!mode[i] && pend_q[i] && !sw_clr[i]) |=> pend_q[i]);

        assert_sw_clear_R3: assert property (@(posedge clk) disable iff (rst)
            (!mode[i] && sw_clr[i] && !rise) |=> !pend_q[i]);

        assert_hw_wins_R6: assert property (@(posedge clk) disable iff (rst)
            (!mode[i] && rise && sw_clr[i]) |=> pend_q[i]);

        assert_level_track_R5: assert property (@(posedge clk) disable iff (rst)
            mode[i] |=> (pend_q[i] == $past(src[i])));

        assert_sw_set_R2: assert property (@(posedge clk) disable iff (rst)
            (!mode[i] && sw_set[i]) |=> pend_q[i]);
    end

    assert_pend_reset_R1: assert property (@(posedge clk)
        rst |=> (pend_q == '0));

endmodule

// File: rtl/irqc_combine.sv
module irqc_combine
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t pend,
    input  src_vec_t mask,
    input  dest_t    dest,
    output logic     irq_local,
    output logic     irq_host
);

    src_vec_t live;
    assign live = pend & mask;

    assign irq_local = |(live & ~dest.route);
    assign irq_host  = |(live & dest.route & dest.target);

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> (!irq_local && !irq_host));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> (!irq_local && !irq_host));

    assert_all_routed_R9: assert property (@(posedge clk) disable iff (rst)
        (dest.route == '1) |-> !irq_local);

    assert_no_target_R10: assert property (@(posedge clk) disable iff (rst)
        (dest.target == '0) |-> !irq_host);

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       src_in,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [7:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq_local,
    output logic              irq_host
);

    wr_strb_t strb;
    src_vec_t mask_q, mode_q, pend_q, sw_set, sw_clr;
    dest_t    dest_q;

    assign strb = decode_write(wr_en, wr_addr);

    irqc_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .strb   (strb),
        .wdata  (wr_data),
        .mask_q (mask_q),
        .mode_q (mode_q),
        .dest_q (dest_q),
        .sw_set (sw_set),
        .sw_clr (sw_clr)
    );

    irqc_pending u_pending (
        .clk    (clk),
        .rst    (rst),
        .src    (src_in),
        .mode   (mode_q),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .pend_q (pend_q)
    );

    irqc_combine u_combine (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend_q),
        .mask      (mask_q),
        .dest      (dest_q),
        .irq_local (irq_local),
        .irq_host  (irq_host)
    );

    localparam int PAD_W = DATA_W - NUM_SRC;

    always_comb begin
        case (rd_addr)
            OFF_STAT: rd_data = {{PAD_W{1'b0}}, pend_q};
            OFF_MODE: rd_data = {{PAD_W{1'b0}}, mode_q};
            OFF_MASK: rd_data = {{PAD_W{1'b0}}, mask_q};
            OFF_DEST: rd_data = dest_q;
            OFF_SUMM: rd_data = {{(DATA_W-1){1'b0}}, irq_host};
            default:  rd_data = '0;
        endcase
    end

    assert_summary_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == OFF_SUMM) |-> (rd_data[DATA_W-1:1] == '0 && rd_data[0] == irq_host));

    assert_strobe_read_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == OFF_PSET || rd_addr == OFF_MCLR) |-> (rd_data == '0));

    assert_ro_write_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == OFF_MASK || wr_addr == OFF_STAT)) |=> $stable(mask_q));

endmodule

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_in = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_local, irq_host;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irqc_top dut_i (
        .clk(clk), .rst(rst), .src_in(src_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_local(irq_local), .irq_host(irq_host)
    );

    typedef struct {
        logic [31:0] data;
        logic        lo;
        logic        ho;
        string       tag;
    } item_t;

    item_t sb[$];

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drive_src(input int idx, input logic v);
        @(negedge clk);
        src_in[idx] = v;
    endtask

    task automatic chk(input logic [7:0] a, input logic [31:0] d,
                       input logic lo, input logic ho, input string tag);
        item_t it;
        rd_addr = a;
        it.data = d; it.lo = lo; it.ho = ho; it.tag = tag;
        sb.push_back(it);
        @(posedge clk);
        #3;
    endtask

    // monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (rd_data !== it.data) begin
                    errors++;
                    $display("FAIL %s: rd_data actual %h expected %h", it.tag, rd_data, it.data);
                end
                checks++;
                if (irq_local !== it.lo || irq_host !== it.ho) begin
                    errors++;
                    $display("FAIL %s: local/host actual %b%b expected %b%b",
                             it.tag, irq_local, irq_host, it.lo, it.ho);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(8'h08, 32'h0, 0, 0, "R1 status");
        chk(8'h18, 32'h0, 0, 0, "R1 mask");
        chk(8'h0C, 32'h0, 0, 0, "R1 mode");
        chk(8'h1C, 32'h0, 0, 0, "R1 dest");

        // R2 software set, masked
        wr(8'h00, 32'h0000_00C0);
        chk(8'h08, 32'h0000_00C0, 0, 0, "R2 set");
        // R7 / R9 enable and local output
        wr(8'h10, 32'h0000_0040);
        chk(8'h18, 32'h0000_0040, 1, 0, "R7 R9 mask set");
        // R3 software clear
        wr(8'h04, 32'h0000_0040);
        chk(8'h08, 32'h0000_0080, 0, 0, "R3 clear");
        wr(8'h14, 32'h0000_0040);
        wr(8'h10, 32'h0000_0080);
        chk(8'h18, 32'h0000_0080, 1, 0, "R7 mask readback");
        // R8 / R10 / R11 routing to host
        wr(8'h1C, 32'h0080_0080);
        chk(8'h1C, 32'h0080_0080, 0, 1, "R8 R10 dest host");
        chk(8'h20, 32'h1, 0, 1, "R11 summary high");
        wr(8'h1C, 32'h0000_0080);
        chk(8'h20, 32'h0, 0, 0, "R10 routed target0");
        wr(8'h04, 32'h0000_FFFF);
        wr(8'h1C, 32'h0);
        chk(8'h08, 32'h0, 0, 0, "R3 clear all");

        // R4 edge latching
        wr(8'h10, 32'h0000_0001);
        drive_src(0, 1'b1);
        chk(8'h08, 32'h0000_0001, 1, 0, "R4 rise");
        drive_src(0, 1'b0);
        chk(8'h08, 32'h0000_0001, 1, 0, "R4 hold after fall");
        wr(8'h04, 32'h0000_0001);
        chk(8'h08, 32'h0, 0, 0, "R3 clear edge");

        // R6 collision
        wr(8'h00, 32'h0000_0002);
        @(negedge clk);
        src_in[1] = 1'b1; wr_en = 1'b1; wr_addr = 8'h04; wr_data = 32'h0000_0002;
        @(negedge clk);
        wr_en = 1'b0;
        chk(8'h08, 32'h0000_0002, 0, 0, "R6 hw beats clear");
        drive_src(1, 1'b0);
        wr(8'h04, 32'h0000_0002);
        chk(8'h08, 32'h0, 0, 0, "R3 clear after collision");

        // R5 level mode
        wr(8'h0C, 32'h0000_0100);
        chk(8'h0C, 32'h0000_0100, 0, 0, "R8 mode readback");
        drive_src(8, 1'b1);
        chk(8'h08, 32'h0000_0100, 0, 0, "R5 level high");
        wr(8'h04, 32'h0000_0100);
        chk(8'h08, 32'h0000_0100, 0, 0, "R5 clear ignored");
        drive_src(8, 1'b0);
        chk(8'h08, 32'h0, 0, 0, "R5 level low");
        wr(8'h00, 32'h0000_0100);
        chk(8'h08, 32'h0, 0, 0, "R5 set ignored");
        wr(8'h0C, 32'h0);

        // R12 read-only writes and strobe reads
        wr(8'h08, 32'h0000_FFFF);
        chk(8'h08, 32'h0, 0, 0, "R12 status write ignored");
        wr(8'h18, 32'h0);
        chk(8'h18, 32'h0000_0081, 0, 0, "R12 mask write ignored");
        wr(8'h20, 32'h1);
        chk(8'h20, 32'h0, 0, 0, "R12 summary write ignored");
        wr(8'h00, 32'h0000_0000);
        chk(8'h00, 32'h0, 0, 0, "R12 set reads zero");

        // R9 / R10 every source to both outputs
        wr(8'h10, 32'h0000_FFFF);
        for (int i = 0; i < 16; i++) begin
            wr(8'h00, 32'h1 << i);
            chk(8'h08, 32'h1 << i, 1, 0, "R9 local route");
            wr(8'h1C, (32'h1 << i) | (32'h1 << (i + 16)));
            chk(8'h20, 32'h1, 0, 1, "R10 host route");
            wr(8'h04, 32'h1 << i);
            wr(8'h1C, 32'h0);
        end
        chk(8'h08, 32'h0, 0, 0, "R3 final idle");

        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule